// File: doc/BRIEF.md
# UTOPIA PHY Receive Cell Port

This block is the PHY-side receive port of an 8-bit UTOPIA Level 1 link. The line side writes a byte stream into an internal buffer. A start-of-cell marker comes with the first byte of each 53-byte ATM cell. The ATM-layer master pulls cells back out one byte per clock, but only on clocks where it holds the receive enable high. The port tells the master when data may be taken through a cell-available flag. On each transferred byte it drives the byte itself, an odd parity bit over it, and a one-clock start-of-cell pulse on the first byte of a cell.

Availability is signalled in one of two ways, chosen at run time. The mode input comes from bit 1 of the chip's control register. In cell mode, which is the default, the flag rises only once a whole cell sits in the buffer. It then stays up until the last byte of that cell has been handed over. In byte mode the flag simply tracks whether the buffer holds any byte, so it can rise early and it falls when the buffer runs dry.

A new line-side cell is admitted only if the buffer has room for all of it at the moment its first byte arrives. Otherwise the whole cell is thrown away and a drop counter advances.

Top module: `utopia_rx_phy`

## Requirements
- R1: After reset rxClav, rxSoc and rxData are 0, rxParity is 1 and dropCount is 0.
- R2: With byteMode low, rxClav is 1 exactly when at least one complete 53-byte cell has been written and not yet fully read out.
- R3: With byteMode low, rxClav stays 1 from the first to the last byte of a cell being read, and can fall only after that cell's last byte has been transferred.
- R4: With byteMode high, rxClav is 1 exactly when the buffer holds at least one byte.
- R5: A byte is transferred on a rising edge only when rxEnb and rxClav are both 1 before that edge; rxData shows that byte after the edge.
- R6: On an edge with no transfer, rxData and rxParity keep their previous values.
- R7: rxSoc is 1 for exactly one clock, following the transfer of a cell's first byte, and 0 otherwise.
- R8: rxParity makes the nine bits {rxParity, rxData} hold an odd number of ones, so rxData of 0 gives rxParity 1.
- R9: A line byte with lineValid and lineSoc both 1, seen while no cell is being written, starts a cell. The cell is stored if the buffer has at least 53 free bytes on that clock. Otherwise all 53 of its bytes are discarded and dropCount (wrapping, 8 bits) increases by 1.
- R10: Bytes leave in the order they were stored and unchanged. lineValid bytes that arrive outside a cell (lineSoc low, no cell in progress) are discarded.
- R11: byteMode low selects cell mode, so a partly written cell never raises rxClav in that mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rstN | input | 1 | Active-low synchronous reset |
| byteMode | input | 1 | 1 selects byte-mode availability, 0 selects cell mode |
| lineValid | input | 1 | Line-side byte present |
| lineSoc | input | 1 | Line-side byte is the first of a cell |
| lineData | input | 8 | Line-side byte |
| rxEnb | input | 1 | Master ready to take a byte |
| rxClav | output | 1 | Data available to the master |
| rxSoc | output | 1 | One-clock start-of-cell marker |
| rxData | output | 8 | Transferred byte |
| rxParity | output | 1 | Odd parity over rxData |
| dropCount | output | 8 | Number of line cells discarded for lack of room |

## Verification
The hardest case to reach is an admission decision taken with the buffer nearly full, where a new cell's first byte lands while older cells are only partly drained. The bench gets there by holding the enable low while it writes three cells back to back into the 128-byte buffer, so the third one meets 22 free bytes and must be dropped whole. Later phases run a pseudo-random enable pattern while cells with gaps keep arriving, so the decision is also taken at shifting fill levels. Byte mode is driven with the enable high while the cell is still being written, so reads chase the writer and the flag toggles byte by byte.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;

  // Strobes from the control block to the datapath
  typedef struct packed {
    logic wrEn;     // store lineData this clock
    logic wrFirst;  // the byte on the line is a cell's first byte
    logic rdEn;     // hand the next stored byte to the master
  } strobe_t;

  // Line-side cell admission state
  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_FILL = 2'd1,
    WR_SKIP = 2'd2
  } wr_state_e;

endpackage

// File: rtl/utopia_rx_ctrl.sv
module utopia_rx_ctrl
  import utopia_rx_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int CELL_LEN = 53,
  parameter int DROP_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteMode,
  input  logic              lineValid,
  input  logic              lineSoc,
  input  logic              rxEnb,
  output strobe_t           strb,
  output logic              rxClav,
  output logic [DROP_W-1:0] dropCount
);

  localparam int CNT_W   = $clog2(DEPTH + 1);
  localparam int IDX_W   = $clog2(CELL_LEN);
  localparam int CELLS_W = $clog2(DEPTH / CELL_LEN + 1);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CELL_C   = CNT_W'(CELL_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_LEN - 1);

  wr_state_e          wrState;
  logic [IDX_W-1:0]   wrIdx;
  logic [IDX_W-1:0]   rdIdx;
  logic [CNT_W-1:0]   occupancy;
  logic [CELLS_W-1:0] cellsReady;

  logic [CNT_W-1:0] freeSpace;
  logic             roomOk;
  logic             startCell;
  logic             wrLast;
  logic             cellStored;
  logic             rdLast;

  always_comb begin
    freeSpace    = DEPTH_C - occupancy;
    roomOk       = freeSpace >= CELL_C;
    startCell    = lineValid && lineSoc && (wrState == WR_IDLE);
    rxClav       = byteMode ? (occupancy != '0) : (cellsReady != '0);
    strb.rdEn    = rxEnb && rxClav;
    strb.wrFirst = startCell;
    strb.wrEn    = (startCell && roomOk) || (lineValid && (wrState == WR_FILL));
    wrLast       = lineValid && (wrState != WR_IDLE) && (wrIdx == LAST_IDX);
    cellStored   = wrLast && (wrState == WR_FILL);
    rdLast       = strb.rdEn && (rdIdx == LAST_IDX);
  end

  // Line-side admission: whole cell stored or whole cell skipped
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrState   <= WR_IDLE;
      wrIdx     <= '0;
      dropCount <= '0;
    end else begin
      unique case (wrState)
        WR_IDLE: begin
          if (startCell) begin
            wrState <= roomOk ? WR_FILL : WR_SKIP;
            wrIdx   <= IDX_W'(1);
            if (!roomOk) dropCount <= dropCount + DROP_W'(1);
          end
        end
        WR_FILL, WR_SKIP: begin
          if (lineValid) begin
            if (wrIdx == LAST_IDX) begin
              wrState <= WR_IDLE;
              wrIdx   <= '0;
            end else begin
              wrIdx <= wrIdx + IDX_W'(1);
            end
          end
        end
        default: begin
          wrState <= WR_IDLE;
          wrIdx   <= '0;
        end
      endcase
    end
  end

  // Byte and cell occupancy, read-side position within a cell
  always_ff @(posedge clk) begin
    if (!rstN) begin
      occupancy  <= '0;
      cellsReady <= '0;
      rdIdx      <= '0;
    end else begin
      unique case ({strb.wrEn, strb.rdEn})
        2'b10:   occupancy <= occupancy + CNT_W'(1);
        2'b01:   occupancy <= occupancy - CNT_W'(1);
        default: occupancy <= occupancy;
      endcase
      unique case ({cellStored, rdLast})
        2'b10:   cellsReady <= cellsReady + CELLS_W'(1);
        2'b01:   cellsReady <= cellsReady - CELLS_W'(1);
        default: cellsReady <= cellsReady;
      endcase
      if (strb.rdEn) rdIdx <= rdLast ? '0 : rdIdx + IDX_W'(1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |-> occupancy < DEPTH_C);  // R9

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |-> occupancy != '0);  // R4

  AST_CLAV_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!byteMode && rdIdx != '0) |-> rxClav);  // R3

  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrState == WR_IDLE && !startCell) |=> dropCount == $past(dropCount));  // R9

endmodule

// File: rtl/utopia_rx_dpath.sv
module utopia_rx_dpath
  import utopia_rx_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] lineData,
  output logic [DATA_W-1:0] rxData,
  output logic              rxSoc,
  output logic              rxParity
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  // Each entry: {first-byte flag, data}
  logic [DATA_W:0]   store [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;
  logic [DATA_W:0]   rdWord;
  logic [DATA_W-1:0] rdByte;

  always_ff @(posedge clk) begin
    if (strb.wrEn) store[wrPtr] <= {strb.wrFirst, lineData};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.wrEn) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + AW'(1);
      if (strb.rdEn) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + AW'(1);
    end
  end

  always_comb begin
    rdWord = store[rdPtr];
    rdByte = rdWord[DATA_W-1:0];
  end

  // Output registers: data and parity hold between transfers, start pulses once
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData   <= '0;
      rxParity <= 1'b1;
      rxSoc    <= 1'b0;
    end else if (strb.rdEn) begin
      rxData   <= rdByte;
      rxParity <= ~^rdByte;
      rxSoc    <= rdWord[DATA_W];
    end else begin
      rxSoc    <= 1'b0;
    end
  end

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEn |=> ($stable(rxData) && $stable(rxParity)));  // R6

  AST_SOC_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rxSoc |=> !rxSoc);  // R7

  AST_ODD_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rxParity, rxData}) % 2 == 1);  // R8

endmodule

// File: rtl/utopia_rx_phy.sv
module utopia_rx_phy
  import utopia_rx_pkg::*;
#(
  parameter int DEPTH    = 128,
  parameter int CELL_LEN = 53,
  parameter int DATA_W   = 8,
  parameter int DROP_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteMode,
  input  logic              lineValid,
  input  logic              lineSoc,
  input  logic [DATA_W-1:0] lineData,
  input  logic              rxEnb,
  output logic              rxClav,
  output logic              rxSoc,
  output logic [DATA_W-1:0] rxData,
  output logic              rxParity,
  output logic [DROP_W-1:0] dropCount
);

  strobe_t strb;

  utopia_rx_ctrl #(
    .DEPTH    (DEPTH),
    .CELL_LEN (CELL_LEN),
    .DROP_W   (DROP_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .byteMode  (byteMode),
    .lineValid (lineValid),
    .lineSoc   (lineSoc),
    .rxEnb     (rxEnb),
    .strb      (strb),
    .rxClav    (rxClav),
    .dropCount (dropCount)
  );

  utopia_rx_dpath #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .lineData (lineData),
    .rxData   (rxData),
    .rxSoc    (rxSoc),
    .rxParity (rxParity)
  );

endmodule

// File: tb/utopia_rx_phy_tb_top.sv
`timescale 1ns/1ps
module utopia_rx_phy_tb_top;

  localparam int DEPTH    = 128;
  localparam int CELL_LEN = 53;
  localparam int DROP_W   = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        rstN = 1'b0;
  logic        byteMode = 1'b0;
  logic        lineValid = 1'b0;
  logic        lineSoc = 1'b0;
  logic [7:0]  lineData = 8'h00;
  logic        rxEnb = 1'b0;
  logic        rxClav;
  logic        rxSoc;
  logic [7:0]  rxData;
  logic        rxParity;
  logic [DROP_W-1:0] dropCount;

  utopia_rx_phy #(.DEPTH(DEPTH), .CELL_LEN(CELL_LEN), .DATA_W(8), .DROP_W(DROP_W)) dut_i (
    .clk(clk), .rstN(rstN), .byteMode(byteMode), .lineValid(lineValid),
    .lineSoc(lineSoc), .lineData(lineData), .rxEnb(rxEnb), .rxClav(rxClav),
    .rxSoc(rxSoc), .rxData(rxData), .rxParity(rxParity), .dropCount(dropCount)
  );

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  // Behavioural reference state
  logic [8:0] mq[$];
  int mComplete = 0;
  int mRdIdx = 0;
  int mWrState = 0;  // 0 idle, 1 storing, 2 skipping
  int mWrIdx = 0;
  int mDrops = 0;
  logic [7:0] mData = 8'h00;
  logic mSoc = 1'b0;
  logic mPar = 1'b1;

  int enbPolicy = 0;  // 0 low, 1 high, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;
  logic nextMode = 1'b0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    logic expClav;
    expClav = byteMode ? (mq.size() != 0) : (mComplete != 0);
    check(rxClav === expClav, byteMode ? "R4" : "R2 R3", "clav", int'(rxClav), int'(expClav));
    check(rxData === mData, "R5 R6 R10", "data", int'(rxData), int'(mData));
    check(rxSoc === mSoc, "R7", "soc", int'(rxSoc), int'(mSoc));
    check(rxParity === mPar, "R8", "parity", int'(rxParity), int'(mPar));
    check(dropCount === DROP_W'(mDrops), "R9", "drops", int'(dropCount), mDrops % 256);
  endtask

  task automatic modelStep();
    int pre;
    bit clavM;
    logic [8:0] e;
    pre = mq.size();
    clavM = byteMode ? (pre != 0) : (mComplete != 0);
    if (rxEnb && clavM) begin
      e = mq.pop_front();
      mData = e[7:0];
      mSoc = e[8];
      mPar = ~^e[7:0];
      mRdIdx++;
      if (mRdIdx == CELL_LEN) begin
        mRdIdx = 0;
        mComplete--;
      end
    end else begin
      mSoc = 1'b0;
    end
    if (lineValid) begin
      case (mWrState)
        0: if (lineSoc) begin
             if (DEPTH - pre >= CELL_LEN) begin
               mq.push_back({1'b1, lineData});
               mWrState = 1;
             end else begin
               mDrops++;
               mWrState = 2;
             end
             mWrIdx = 1;
           end
        1: begin
             mq.push_back({1'b0, lineData});
             mWrIdx++;
             if (mWrIdx == CELL_LEN) begin
               mWrState = 0;
               mWrIdx = 0;
               mComplete++;
             end
           end
        default: begin
             mWrIdx++;
             if (mWrIdx == CELL_LEN) begin
               mWrState = 0;
               mWrIdx = 0;
             end
           end
      endcase
    end
  endtask

  task automatic step(input bit v, input bit s, input logic [7:0] d);
    @(negedge clk);
    compareAll();
    byteMode = nextMode;
    lineValid = v;
    lineSoc = s;
    lineData = d;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rxEnb = (enbPolicy == 1) || (enbPolicy == 2 && (lfsr[0] || lfsr[3]));
    modelStep();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 8'h00);
  endtask

  function automatic logic [7:0] cellByte(input int id, input int i);
    if (id == 0) return 8'h00;
    return 8'((id * 37 + i * 11 + (i == 5 ? 200 : 0)) & 255);
  endfunction

  task automatic sendCell(input int id, input bit gaps);
    for (int i = 0; i < CELL_LEN; i++) begin
      step(1'b1, i == 0, cellByte(id, i));
      if (gaps && (i % 7 == 3)) step(1'b0, 1'b0, 8'h00);
    end
  endtask

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(rxClav === 1'b0, "R1", "clav", int'(rxClav), 0);
    check(rxSoc === 1'b0, "R1", "soc", int'(rxSoc), 0);
    check(rxData === 8'h00, "R1", "data", int'(rxData), 0);
    check(rxParity === 1'b1, "R1", "parity", int'(rxParity), 1);
    check(dropCount === '0, "R1", "drops", int'(dropCount), 0);
    rstN = 1'b1;

    // R10: stray bytes outside any cell are discarded
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'(8'hA0 + i));
    step(1'b0, 1'b0, 8'h00);
    check(rxClav === 1'b0, "R10", "clav after stray", int'(rxClav), 0);

    // R11: cell mode by default, partial cell keeps clav low
    for (int i = 0; i < CELL_LEN; i++) begin
      step(1'b1, i == 0, cellByte(0, i));
      if (i == 20) check(rxClav === 1'b0, "R11", "clav partial", int'(rxClav), 0);
    end
    step(1'b0, 1'b0, 8'h00);
    check(rxClav === 1'b1, "R2", "clav full cell", int'(rxClav), 1);

    // R9: third cell meets too little room and is dropped
    sendCell(1, 1'b0);
    sendCell(2, 1'b0);
    step(1'b0, 1'b0, 8'h00);
    check(dropCount === DROP_W'(1), "R9", "drop count", int'(dropCount), 1);

    // R7 R8: first byte of all-zero cell
    enbPolicy = 1;
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    check(rxSoc === 1'b1, "R7", "soc first", int'(rxSoc), 1);
    check(rxParity === 1'b1 && rxData === 8'h00, "R8", "zero parity", int'(rxParity), 1);
    step(1'b0, 1'b0, 8'h00);
    check(rxSoc === 1'b0, "R7", "soc second", int'(rxSoc), 0);

    // R6: enable dropped, outputs hold
    enbPolicy = 0;
    idle(60);
    enbPolicy = 1;
    idle(20);
    enbPolicy = 0;
    step(1'b0, 1'b0, 8'h00);
    held = rxData;
    idle(4);
    check(rxData === held, "R6", "hold", int'(rxData), int'(held));

    // R5 R3: random enable with cells arriving
    enbPolicy = 2;
    for (int c = 3; c < 9; c++) begin
      sendCell(c, c[0]);
      idle(c);
    end
    idle(300);

    // R4: byte mode, reads chase the writer
    nextMode = 1'b1;
    enbPolicy = 0;
    idle(2);
    for (int i = 0; i < CELL_LEN; i++) begin
      step(1'b1, i == 0, cellByte(9, i));
      if (i == 1) check(rxClav === 1'b1, "R4", "clav early", int'(rxClav), 1);
      if (i == 2) enbPolicy = 1;
    end
    idle(80);
    enbPolicy = 2;
    for (int c = 10; c < 14; c++) begin
      sendCell(c, 1'b1);
      idle(c % 5);
    end
    idle(300);

    // Back to cell mode
    nextMode = 1'b0;
    for (int c = 14; c < 16; c++) sendCell(c, 1'b1);
    idle(300);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule